// File: doc/BRIEF.md
# MII Receive Byte Framer

This block sits on the receive side of a 10/100 Ethernet MAC, in the receive clock domain. It watches the 4-bit MII receive nibble stream and its data-valid qualifier. It hunts for the preamble and the start-of-frame delimiter and strips both. It then pairs the following nibbles into bytes and hands each byte to host logic on an 8-bit bus. Strobes mark the first byte, the last byte and the span of the packet.

Bytes arrive from the line every two clocks, and each byte stays on the host bus for exactly two clocks. The block holds each completed byte back by one byte slot. This is how it knows, when a byte is released, whether that byte closes the packet. The end-of-frame flag therefore lands on the last byte itself and not one byte later.

The block also produces its own receive-domain reset from an active-low system reset that may change at any time. That reset asserts at once and releases in step with the receive clock. The system reset must be held low for at least 400 ns at 100 Mb/s and for at least 4000 ns at 10 Mb/s.

Top module: `mii_rx_framer`

## Requirements
- R1: Every byte presented on `host_data` stays unchanged for exactly two consecutive clock cycles while `host_valid` is high.
- R2: `host_sof` is high for exactly one cycle. That cycle is the first cycle of the first data byte's two-cycle window.
- R3: `host_eof` is high for exactly one cycle. That cycle is the first cycle of the last complete byte's two-cycle window.
- R4: `host_valid` rises together with `host_sof`, stays high through every byte of the packet, and falls in the cycle right after the last byte's two-cycle window.
- R5: Any number (one or more) of preamble nibbles of value 0x5, followed by the delimiter nibble 0xD, are accepted. None of these nibbles appears on `host_data`.
- R6: Within each byte, the first data nibble received forms bits 3:0 and the second forms bits 7:4.
- R7: If `mii_dv` falls after an odd number of data nibbles, the leftover nibble is dropped and the last complete byte carries `host_eof`.
- R8: A packet of a single byte shows `host_sof` and `host_eof` high in the same cycle.
- R9: A nibble other than 0x5 or 0xD before the delimiter, or a 0xD without a preceding 0x5, makes the block ignore the rest of that burst until `mii_dv` goes low. No byte is output.
- R10: `rx_rst_n` goes low as soon as `sys_rst_n` goes low, without waiting for a clock edge. After `sys_rst_n` rises, `rx_rst_n` goes high on the second rising clock edge.
- R11: A byte's window begins on the second rising edge after the edge that samples its second nibble. Consecutive byte windows follow one another with no gap.
- R12: While `rx_rst_n` is low, `host_valid`, `host_sof` and `host_eof` are low. This holds even when reset arrives in the middle of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | MII receive clock |
| sys_rst_n | input | 1 | Active-low system reset, asynchronous |
| mii_dv | input | 1 | MII receive data valid |
| mii_nib | input | 4 | MII receive nibble |
| rx_rst_n | output | 1 | Receive-domain reset: asserts at once, releases synchronously |
| host_data | output | 8 | Received byte, held for two cycles |
| host_sof | output | 1 | First-byte pulse |
| host_eof | output | 1 | Last-byte pulse |
| host_valid | output | 1 | High from the first byte to the end of the last byte's window |

## Verification
Packets are sent with short and long preambles, so the delimiter hunt has to cope with different lead-in lengths. The data bytes mix nibble values such as 0xA5, 0x5A and 0xD5. A swapped nibble order, or a delimiter match left active inside the data, then shows up as a wrong byte. Frames of one byte, of an odd nibble count and of many bytes separate the first/last flag logic from the hold timing. Bursts with a broken preamble and a reset in the middle of a packet check that nothing leaks onto the host bus.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  parameter int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 2 * NIB_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DROP,
    ST_DATA,
    ST_TAIL
  } hunt_state_e;

  // first nibble on the line is the low half of the byte
  function automatic logic [BYTE_W-1:0] join_nibbles(input logic [NIB_W-1:0] first_nib,
                                                     input logic [NIB_W-1:0] second_nib);
    return {second_nib, first_nib};
  endfunction
endpackage

// File: rtl/rx_reset_sync.sv
module rx_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[LAST-1:0], 1'b1};
  end

  assign rst_n = chain[LAST];

  // R10: the local reset is low whenever the system reset is low
  a_r10_low_in_reset: assert property (@(posedge clk) !arst_n |-> !rst_n);
endmodule

// File: rtl/rx_sfd_packer.sv
module rx_sfd_packer
  import mii_rx_pkg::*;
#(
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dv,
  input  logic [NIB_W-1:0]  nib,
  output logic              emit,
  output logic [BYTE_W-1:0] emit_byte,
  output logic              emit_first,
  output logic              emit_last
);
  hunt_state_e       state;
  logic              phase;
  logic [NIB_W-1:0]  lo_nib;
  logic [BYTE_W-1:0] pend_byte;
  logic              pend_valid;
  logic              pend_first;

  // named internal events
  logic byte_done;
  logic frame_end_now;
  logic slot;

  assign byte_done     = (state == ST_DATA) && dv && phase;
  assign frame_end_now = ((state == ST_DATA) && !dv && phase) || (state == ST_TAIL);
  assign slot          = byte_done || frame_end_now;

  assign emit       = slot && pend_valid;
  assign emit_byte  = pend_byte;
  assign emit_first = pend_first;
  assign emit_last  = frame_end_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phase      <= 1'b0;
      lo_nib     <= '0;
      pend_byte  <= '0;
      pend_valid <= 1'b0;
      pend_first <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          phase      <= 1'b0;
          pend_valid <= 1'b0;
          if (dv) state <= (nib == PRE_NIB) ? ST_PRE : ST_DROP;
        end
        ST_PRE: begin
          if (!dv)                 state <= ST_IDLE;
          else if (nib == SFD_NIB) begin
            state <= ST_DATA;
            phase <= 1'b0;
          end
          else if (nib != PRE_NIB) state <= ST_DROP;
        end
        ST_DROP: begin
          if (!dv) state <= ST_IDLE;
        end
        ST_DATA: begin
          if (dv) begin
            if (!phase) begin
              lo_nib <= nib;
              phase  <= 1'b1;
            end else begin
              pend_byte  <= join_nibbles(lo_nib, nib);
              pend_first <= !pend_valid;
              pend_valid <= 1'b1;
              phase      <= 1'b0;
            end
          end else if (phase) begin
            state      <= ST_IDLE;
            pend_valid <= 1'b0;
          end else begin
            state <= ST_TAIL;
            phase <= 1'b1;
          end
        end
        ST_TAIL: begin
          state      <= ST_IDLE;
          pend_valid <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: released bytes are at least two cycles apart
  a_r11_emit_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> !emit);
  // R5: a delimiter seen mid-hunt leads straight to data collection
  a_r5_sfd_enters_data: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRE && dv && nib == SFD_NIB) |=> (state == ST_DATA && !phase));
endmodule

// File: rtl/rx_byte_window.sv
module rx_byte_window
  import mii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic [BYTE_W-1:0] emit_byte,
  input  logic              emit_first,
  input  logic              emit_last,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_valid
);
  logic win_first;
  logic last_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_valid <= 1'b0;
      win_first <= 1'b0;
      last_hold <= 1'b0;
    end else if (emit) begin
      out_data  <= emit_byte;
      out_sof   <= emit_first;
      out_eof   <= emit_last;
      out_valid <= 1'b1;
      win_first <= 1'b1;
      last_hold <= emit_last;
    end else begin
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      win_first <= 1'b0;
      if (!win_first && last_hold) out_valid <= 1'b0;
    end
  end

  // R1: a byte stays for its second cycle
  a_r1_hold_two: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && win_first) |=> (out_valid && $stable(out_data)));
  // R2: start pulse lasts one cycle
  a_r2_sof_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |=> !out_sof);
  // R3: end pulse lasts one cycle
  a_r3_eof_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> !out_eof);
  // R4: start pulse only with valid
  a_r4_sof_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
  import mii_rx_pkg::*;
#(
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [NIB_W-1:0] PRE_NIB     = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB     = 4'hD
) (
  input  logic              clk_rx,
  input  logic              sys_rst_n,
  input  logic              mii_dv,
  input  logic [NIB_W-1:0]  mii_nib,
  output logic              rx_rst_n,
  output logic [BYTE_W-1:0] host_data,
  output logic              host_sof,
  output logic              host_eof,
  output logic              host_valid
);
  logic              emit;
  logic [BYTE_W-1:0] emit_byte;
  logic              emit_first;
  logic              emit_last;

  rx_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk_rx),
    .arst_n (sys_rst_n),
    .rst_n  (rx_rst_n)
  );

  rx_sfd_packer #(.PRE_NIB(PRE_NIB), .SFD_NIB(SFD_NIB)) u_pack (
    .clk        (clk_rx),
    .rst_n      (rx_rst_n),
    .dv         (mii_dv),
    .nib        (mii_nib),
    .emit       (emit),
    .emit_byte  (emit_byte),
    .emit_first (emit_first),
    .emit_last  (emit_last)
  );

  rx_byte_window u_win (
    .clk        (clk_rx),
    .rst_n      (rx_rst_n),
    .emit       (emit),
    .emit_byte  (emit_byte),
    .emit_first (emit_first),
    .emit_last  (emit_last),
    .out_data   (host_data),
    .out_sof    (host_sof),
    .out_eof    (host_eof),
    .out_valid  (host_valid)
  );

  // R12: no strobe escapes while the receive reset is low
  a_r12_quiet_in_reset: assert property (@(posedge clk_rx)
    !rx_rst_n |-> (!host_valid && !host_sof && !host_eof));
endmodule

// File: tb/mii_rx_framer_test.sv
module mii_rx_framer_test;
  logic       clk = 1'b0;
  logic       sys_rst_n;
  logic       mii_dv;
  logic [3:0] mii_nib;
  logic       rx_rst_n;
  logic [7:0] host_data;
  logic       host_sof, host_eof, host_valid;

  always #4 clk = ~clk;

  mii_rx_framer uut (
    .clk_rx     (clk),
    .sys_rst_n  (sys_rst_n),
    .mii_dv     (mii_dv),
    .mii_nib    (mii_nib),
    .rx_rst_n   (rx_rst_n),
    .host_data  (host_data),
    .host_sof   (host_sof),
    .host_eof   (host_eof),
    .host_valid (host_valid)
  );

  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  bit    chk_on = 1'b0;
  bit    done = 1'b0;
  string tag = "reset";

  bit         ev[int];
  logic [7:0] ed[int];
  bit         es[int];
  bit         ee[int];
  logic [7:0] fq[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL [%s] %s at cycle %0d: actual=%0h expected=%0h", tag, req, cyc, act, exp);
    end
  endtask

  // reference model compare on every cycle
  always @(negedge clk) begin
    if (chk_on) begin
      bit         xv, xs, xe;
      logic [7:0] xd;
      xv = ev.exists(cyc) ? ev[cyc] : 1'b0;
      xs = es.exists(cyc) ? es[cyc] : 1'b0;
      xe = ee.exists(cyc) ? ee[cyc] : 1'b0;
      xd = ed.exists(cyc) ? ed[cyc] : 8'h00;
      check(host_valid === xv, "R4 valid", int'(host_valid), int'(xv));
      check(host_sof === xs, "R2 sof", int'(host_sof), int'(xs));
      check(host_eof === xe, "R3 eof", int'(host_eof), int'(xe));
      if (xv) check(host_data === xd, "R1/R6 data", int'(host_data), int'(xd));
    end
  end

  task automatic drive(input bit dv, input logic [3:0] n);
    @(negedge clk);
    mii_dv  = dv;
    mii_nib = n;
  endtask

  // sends the bytes in fq; each byte appears 2 edges after its second nibble (R11)
  task automatic send_frame(input int npre, input bit odd);
    int last;
    last = fq.size() - 1;
    for (int p = 0; p < npre; p++) drive(1'b1, 4'h5);
    drive(1'b1, 4'hD);
    for (int i = 0; i <= last; i++) begin
      int e;
      drive(1'b1, fq[i][3:0]);
      drive(1'b1, fq[i][7:4]);
      e = cyc + 1;
      ev[e+2] = 1'b1;  ev[e+3] = 1'b1;
      ed[e+2] = fq[i]; ed[e+3] = fq[i];
      if (i == 0)    es[e+2] = 1'b1;
      if (i == last) ee[e+2] = 1'b1;
    end
    if (odd) drive(1'b1, 4'hA);
    for (int g = 0; g < 6; g++) drive(1'b0, 4'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL [watchdog] run did not finish: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    sys_rst_n = 1'b0;
    mii_dv    = 1'b0;
    mii_nib   = 4'h0;
    repeat (3) @(negedge clk);
    chk_on = 1'b1;
    check(rx_rst_n === 1'b0, "R10 reset held", int'(rx_rst_n), 0);
    check(host_valid === 1'b0 && host_sof === 1'b0 && host_eof === 1'b0,
          "R12 outputs in reset", int'(host_valid), 0);
    sys_rst_n = 1'b1;
    @(negedge clk);
    check(rx_rst_n === 1'b0, "R10 one edge after release", int'(rx_rst_n), 0);
    @(negedge clk);
    check(rx_rst_n === 1'b1, "R10 two edges after release", int'(rx_rst_n), 1);

    tag = "R5 long preamble";
    fq.delete();
    fq.push_back(8'h11); fq.push_back(8'h22); fq.push_back(8'h33); fq.push_back(8'h44);
    send_frame(15, 1'b0);

    tag = "R6 nibble order";
    fq.delete();
    fq.push_back(8'hA5); fq.push_back(8'h5A); fq.push_back(8'hD5); fq.push_back(8'h0F);
    send_frame(3, 1'b0);

    tag = "R8 single byte";
    fq.delete();
    fq.push_back(8'h7E);
    send_frame(1, 1'b0);

    tag = "R7 odd tail";
    fq.delete();
    fq.push_back(8'h01); fq.push_back(8'h02); fq.push_back(8'h93);
    send_frame(5, 1'b1);

    tag = "R9 broken preamble";
    drive(1'b1, 4'h5); drive(1'b1, 4'h5); drive(1'b1, 4'h3); drive(1'b1, 4'h5);
    drive(1'b1, 4'hD); drive(1'b1, 4'h1); drive(1'b1, 4'h2);
    for (int g = 0; g < 6; g++) drive(1'b0, 4'h0);
    tag = "R9 bare delimiter";
    drive(1'b1, 4'hD); drive(1'b1, 4'h4); drive(1'b1, 4'h8);
    for (int g = 0; g < 6; g++) drive(1'b0, 4'h0);

    tag = "R11 long frame";
    fq.delete();
    for (int b = 0; b < 20; b++) fq.push_back(8'((b * 37 + 3) & 8'hFF));
    send_frame(7, 1'b0);

    tag = "R12 reset mid frame";
    chk_on = 1'b0;
    for (int p = 0; p < 4; p++) drive(1'b1, 4'h5);
    drive(1'b1, 4'hD);
    for (int n = 0; n < 8; n++) drive(1'b1, 4'(n + 6));
    #1 sys_rst_n = 1'b0;
    #1;
    check(rx_rst_n === 1'b0, "R10 immediate assert", int'(rx_rst_n), 0);
    check(host_valid === 1'b0 && host_sof === 1'b0 && host_eof === 1'b0,
          "R12 outputs cleared", int'(host_valid), 0);
    mii_dv = 1'b0;
    @(negedge clk);
    chk_on = 1'b1;
    repeat (2) @(negedge clk);
    sys_rst_n = 1'b1;
    @(negedge clk);
    check(rx_rst_n === 1'b0, "R10 one edge after release", int'(rx_rst_n), 0);
    @(negedge clk);
    check(rx_rst_n === 1'b1, "R10 two edges after release", int'(rx_rst_n), 1);

    tag = "R12 frame after reset";
    fq.delete();
    fq.push_back(8'hC3); fq.push_back(8'h3C);
    send_frame(2, 1'b1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule